// File: doc/BRIEF.md
# Nibble-Multiplexed Byte Read Sequencer

This block fetches an 8-bit converter result through a narrow input port that carries only four useful data lines. On a start command it performs a fixed sequence:

1. It pulses a trigger line to begin a conversion.
2. It waits a fixed number of clock cycles, because the converter's completion strobe is too brief to be used.
3. It reads the upper nibble, then flips a select line so that an external 2:1 selector presents the lower nibble, and reads that as well.

The port's most significant input line carries inverted data. Both control lines are inverted at the pins. The block corrects every one of these inversions itself.

The lower nibble is moved down with a zero-filling shift and merged with the masked upper nibble. The assembled byte is presented together with a one-cycle done pulse. The converter and the selector lie outside the block; the host logic only issues start and consumes the result.

Top module: `nbr_byte_reader`

## Requirements
- R1: While and right after synchronous reset, `trig_pin` and `sel_pin` are high (both control lines idle, since a logical 1 drives a pin low), `done` is 0 and `result` is 0.
- R2: A start accepted while idle gives one idle cycle, then exactly one cycle with `trig_pin` low, then `trig_pin` high again; one transaction has exactly one trigger cycle.
- R3: The upper nibble is sampled after a blind wait of exactly `WAIT_CYCLES` cycles (default 255). `done` rises exactly `WAIT_CYCLES + 7` clock edges after the edge that accepted start, counting that edge.
- R4: The upper nibble is read while `sel_pin` is high. It is taken from `stat_in[7:4]` with bit 7 inverted, and it becomes `result[7:4]`.
- R5: The lower nibble is read while `sel_pin` is low, which holds for exactly two cycles per transaction. It is taken from `stat_in[7:4]` with bit 7 inverted, and it becomes `result[3:0]`.
- R6: `stat_in[3:0]` has no effect on `result`, whatever value it carries during either read.
- R7: `result` equals the converter byte for every one of the 256 possible values.
- R8: `done` is high for exactly one cycle with the new `result`. `sel_pin` is high while `done` is high. `result` holds its value whenever `done` is low.
- R9: `start` is ignored while a transaction is in progress: it produces no extra trigger and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one byte read; accepted only when idle |
| stat_in | input | 8 | Port input byte; bits 7:4 carry a nibble, bit 7 inverted |
| trig_pin | output | 1 | Conversion trigger pin, active low |
| sel_pin | output | 1 | Nibble select pin; high selects upper nibble |
| result | output | 8 | Assembled converter byte |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
The checker watches every cycle for the following:
- the single-cycle trigger;
- the exact gap between the trigger release and the select assertion, counted by its own counter;
- the two-cycle select window;
- the two control lines never being asserted together;
- the one-cycle done pulse with select idle;
- the result holding still between pulses.

Only the bench scenarios can show that the byte is assembled correctly under inversion and junk on the low lines. A converter model that returns stale data until the exact moment the wait ends shows whether that wait is long enough. The bench scenarios also show that start requests made mid-transaction really vanish.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

    localparam int PORT_W = 8;
    localparam int NIB_W  = PORT_W / 2;

    localparam logic [PORT_W-1:0] INV_MASK = PORT_W'(1) << (PORT_W - 1);
    localparam logic [PORT_W-1:0] HI_MASK  = {{NIB_W{1'b1}}, {NIB_W{1'b0}}};

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ARM,
        ST_TRIG,
        ST_REST,
        ST_WAIT,
        ST_RDHI,
        ST_SELLO,
        ST_RDLO,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic trig;
        logic sel;
    } ctl_cmd_t;

    function automatic logic [PORT_W-1:0] fix_port(input logic [PORT_W-1:0] p);
        return p ^ INV_MASK;
    endfunction

endpackage

// File: rtl/nbr_wait_timer.sv
module nbr_wait_timer #(
    parameter int WAIT_CYCLES = 255
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(WAIT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/nbr_pin_drive.sv
module nbr_pin_drive
    import nbr_pkg::*;
#(
    parameter bit PIN_INVERT = 1'b1
) (
    input  ctl_cmd_t cmd,
    output logic     trig_pin,
    output logic     sel_pin
);
    generate
        if (PIN_INVERT) begin : g_inv
            assign trig_pin = ~cmd.trig;
            assign sel_pin  = ~cmd.sel;
        end else begin : g_dir
            assign trig_pin = cmd.trig;
            assign sel_pin  = cmd.sel;
        end
    endgenerate
endmodule

// File: rtl/nbr_nibble_join.sv
module nbr_nibble_join
    import nbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_hi,
    input  logic              cap_lo,
    input  logic [PORT_W-1:0] port_in,
    output logic [PORT_W-1:0] result
);
    logic [PORT_W-1:0] fixed;
    logic [PORT_W-1:0] hi_q;

    assign fixed = fix_port(port_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            result <= '0;
        end else begin
            if (cap_hi) begin
                hi_q <= fixed & HI_MASK;
            end
            if (cap_lo) begin
                result <= hi_q | (fixed >> NIB_W);
            end
        end
    end
endmodule

// File: rtl/nbr_byte_reader.sv
module nbr_byte_reader
    import nbr_pkg::*;
#(
    parameter int WAIT_CYCLES = 255,
    parameter bit PIN_INVERT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PORT_W-1:0] stat_in,
    output logic              trig_pin,
    output logic              sel_pin,
    output logic [PORT_W-1:0] result,
    output logic              done
);
    seq_state_e state, state_nx;
    ctl_cmd_t   cmd;
    logic       wait_run;
    logic       wait_exp;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_ARM;
            ST_ARM:   state_nx = ST_TRIG;
            ST_TRIG:  state_nx = ST_REST;
            ST_REST:  state_nx = ST_WAIT;
            ST_WAIT:  if (wait_exp) state_nx = ST_RDHI;
            ST_RDHI:  state_nx = ST_SELLO;
            ST_SELLO: state_nx = ST_RDLO;
            ST_RDLO:  state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    assign wait_run = (state == ST_WAIT);
    assign cmd.trig = (state == ST_TRIG);
    assign cmd.sel  = (state == ST_SELLO) || (state == ST_RDLO);
    assign done     = (state == ST_DONE);

    nbr_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (wait_run),
        .expired (wait_exp)
    );

    nbr_pin_drive #(.PIN_INVERT(PIN_INVERT)) u_pins (
        .cmd      (cmd),
        .trig_pin (trig_pin),
        .sel_pin  (sel_pin)
    );

    nbr_nibble_join u_join (
        .clk     (clk),
        .rst     (rst),
        .cap_hi  (state == ST_RDHI),
        .cap_lo  (state == ST_RDLO),
        .port_in (stat_in),
        .result  (result)
    );
endmodule

// File: rtl/nbr_byte_reader_chk.sv
module nbr_byte_reader_chk
    import nbr_pkg::*;
#(
    parameter int WAIT_CYCLES = 255,
    parameter bit PIN_INVERT  = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              trig_pin,
    input logic              sel_pin,
    input logic [PORT_W-1:0] result,
    input logic              done
);
    localparam int GW = $clog2(WAIT_CYCLES + 4) + 1;
    localparam logic [GW-1:0] GAP = GW'(WAIT_CYCLES + 2);
    localparam logic [GW-1:0] SAT = GW'(WAIT_CYCLES + 3);

    logic trig_act, sel_act;
    logic [GW-1:0] gap_cnt;

    assign trig_act = PIN_INVERT ? ~trig_pin : trig_pin;
    assign sel_act  = PIN_INVERT ? ~sel_pin  : sel_pin;

    always_ff @(posedge clk) begin
        if (rst || trig_act) begin
            gap_cnt <= '0;
        end else if (gap_cnt != SAT) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $rose(trig_act) |=> !trig_act); // R2
    AST_WAIT_EXACT: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_act) |-> (gap_cnt == GAP)); // R3
    AST_SEL_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_act) |=> sel_act ##1 !sel_act); // R5
    AST_CTL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(trig_act && sel_act)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_DONE_SEL_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !sel_act && $past(sel_act)); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result)); // R8
endmodule

bind nbr_byte_reader nbr_byte_reader_chk #(
    .WAIT_CYCLES (WAIT_CYCLES),
    .PIN_INVERT  (PIN_INVERT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .trig_pin (trig_pin),
    .sel_pin  (sel_pin),
    .result   (result),
    .done     (done)
);

// File: tb/tb_nbr_byte_reader.sv
module tb_nbr_byte_reader;
    localparam int W = 255;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] stat_in;
    logic       trig_pin, sel_pin, done;
    logic [7:0] result;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // converter + selector model
    logic [7:0] conv_val = 8'h00;
    logic [3:0] junk = 4'hF;
    int         m_cnt = 0;
    logic [7:0] conv_out;
    logic [3:0] nib;

    always #2 clk = ~clk;

    nbr_byte_reader dut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .stat_in  (stat_in),
        .trig_pin (trig_pin),
        .sel_pin  (sel_pin),
        .result   (result),
        .done     (done)
    );

    always @(negedge clk) begin
        if (!trig_pin) m_cnt <= 0;
        else if (m_cnt < W + 10) m_cnt <= m_cnt + 1;
    end

    assign conv_out = (m_cnt >= W + 2) ? conv_val : ~conv_val;
    assign nib      = sel_pin ? conv_out[7:4] : conv_out[3:0];
    assign stat_in  = {nib ^ 4'b1000, junk};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_one(input logic [7:0] v, input logic [3:0] j, input bit poke);
        int lat = 0;
        int trigs = 0;
        int sels = 0;
        logic [7:0] held;
        conv_val = v;
        junk = j;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < W + 40) begin
            if (!trig_pin) trigs++;
            if (!sel_pin) sels++;
            if (poke && (lat == 10 || lat == 120 || lat == W + 5)) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        chk(lat == W + 7, "R3 latency", lat, W + 7);
        chk(trigs == 1, "R2 trigger cycles", trigs, 1);
        chk(sels == 2, "R5 select-low cycles", sels, 2);
        chk(result == v, "R7 byte", result, v);
        chk(result[7:4] == v[7:4], "R4 upper nibble", result[7:4], v[7:4]);
        chk(result[3:0] == v[3:0], "R5 lower nibble", result[3:0], v[3:0]);
        if (j != 4'hF) chk(result == v, "R6 low lines ignored", result, v);
        chk(sel_pin == 1'b1, "R8 select idle at done", sel_pin, 1);
        held = result;
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", done, 0);
        if (poke) begin
            trigs = 0;
            for (int k = 0; k < W + 20; k++) begin
                if (!trig_pin || done) trigs++;
                @(negedge clk);
            end
            chk(trigs == 0, "R9 start ignored while busy", trigs, 0);
        end else begin
            for (int k = 0; k < 3; k++) @(negedge clk);
        end
        chk(result == held, "R8 result held", result, held);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk(trig_pin == 1'b1, "R1 trig in reset", trig_pin, 1);
        chk(sel_pin == 1'b1, "R1 sel in reset", sel_pin, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(result == 8'h00, "R1 result after reset", result, 0);
        chk(trig_pin && sel_pin, "R1 pins idle after reset", {trig_pin, sel_pin}, 3);
        for (int v = 0; v < 256; v++) begin
            run_one(8'(v), (v % 3 == 0) ? 4'hF : 4'((v * 7) ^ 5), 1'b0);
        end
        run_one(8'hA5, 4'h0, 1'b1);
        run_one(8'h3C, 4'h6, 1'b0);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 190000; c++) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule